// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This block is a small 32-bit processor core that completes one instruction per clock cycle. In each cycle it fetches the word at the program counter, decodes it, reads two source registers and runs the operation through an ALU. Where the instruction calls for it, the cycle ends with a write to the register file or to data memory, and the program counter is always updated. Nine instructions are recognised: a word load, a word store, add, subtract, bitwise and, bitwise or, signed set-less-than, branch on equal and an absolute jump.

Instruction memory and data memory are small word arrays inside the core. While reset is held, a simple load port fills them. The core reports its activity on its ports: the current program counter and instruction, the register write it is committing, and the store it is committing. A surrounding bench or system can follow execution from these ports alone.

Top module: `mini_cpu32`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets the program counter to 0 and clears all 32 registers to 0.
- R2: For every instruction other than a taken branch or a jump, the next program counter is the current one plus 4, and the program counter stays word aligned.
- R3: Register-format instructions (opcode bits [31:26] = 0x00) read sources from bits [25:21] and [20:16] and write the destination named by bits [15:11]. The function field bits [5:0] selects the operation: 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x2A signed set-less-than, which gives 1 or 0.
- R4: A load (opcode 0x23) forms the address as the register at [25:21] plus the sign-extended bits [15:0]. It writes the data memory word at address bits [DMEM_AW+1:2] into the register named by [20:16].
- R5: A store (opcode 0x2B) writes the register at [20:16] to the data memory word at the same computed address. It raises `mem_we` and does not write any register.
- R6: A branch (opcode 0x04) compares the registers at [25:21] and [20:16]. When they are equal, the next program counter is PC+4 plus the sign-extended offset shifted left by 2; otherwise it is PC+4. A branch writes neither registers nor memory.
- R7: A jump (opcode 0x02) sets the program counter to the upper 4 bits of PC+4, followed by bits [25:0] and two zero bits. A jump writes neither registers nor memory.
- R8: Register 0 always reads as 0, and a write aimed at it is dropped, with `reg_we` held low.
- R9: While `rst` is high, `ld_imem_we` or `ld_dmem_we` writes `ld_data` into instruction or data memory at word index `ld_addr`. The instruction at PC is presented on `instr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ld_imem_we | input | 1 | Write `ld_data` into instruction memory |
| ld_dmem_we | input | 1 | Write `ld_data` into data memory |
| ld_addr | input | IMEM_AW | Word index for the load port |
| ld_data | input | 32 | Word written by the load port |
| pc | output | 32 | Current program counter |
| instr | output | 32 | Instruction fetched at `pc` |
| reg_we | output | 1 | A register write commits at the next edge |
| reg_waddr | output | 5 | Destination register of that write |
| reg_wdata | output | 32 | Value of that write |
| mem_we | output | 1 | A data memory store commits at the next edge |
| mem_addr | output | 32 | Byte address computed by the ALU |
| mem_wdata | output | 32 | Store data |

## Verification
The assertions assume that every fetched word is one of the nine supported encodings and that the load port stays idle once reset is released. The bench meets both conditions. It fills the memories only while reset is held, and it builds the program only from the nine encodings. That program has word-aligned data addresses inside data memory and control flow that stays inside instruction memory. A register sweep runs every supported operation over every pair of operands drawn from a set of edge values, and the bench predicts each write from its own model of the instruction set.

// File: rtl/mini_cpu32.sv
module mini_cpu32 #(
  parameter int IMEM_AW = 8,
  parameter int DMEM_AW = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ld_imem_we,
  input  logic               ld_dmem_we,
  input  logic [IMEM_AW-1:0] ld_addr,
  input  logic [31:0]        ld_data,
  output logic [31:0]        pc,
  output logic [31:0]        instr,
  output logic               reg_we,
  output logic [4:0]         reg_waddr,
  output logic [31:0]        reg_wdata,
  output logic               mem_we,
  output logic [31:0]        mem_addr,
  output logic [31:0]        mem_wdata
);
  localparam int IMEM_WORDS = 1 << IMEM_AW;
  localparam int DMEM_WORDS = 1 << DMEM_AW;

  localparam logic [5:0] OP_REG = 6'h00, OP_LD = 6'h23, OP_ST = 6'h2B,
                         OP_BR  = 6'h04, OP_JMP = 6'h02;
  localparam logic [5:0] FN_ADD = 6'h20, FN_SUB = 6'h22, FN_AND = 6'h24,
                         FN_OR  = 6'h25, FN_SLT = 6'h2A;
  localparam logic [2:0] A_AND = 3'd0, A_OR = 3'd1, A_ADD = 3'd2,
                         A_SUB = 3'd6, A_SLT = 3'd7;

  logic [31:0] imem [IMEM_WORDS];
  logic [31:0] dmem [DMEM_WORDS];
  logic [31:0] rf   [32];
  logic [31:0] pc_q;

  logic [5:0]  opcode, funct;
  logic [4:0]  rs, rt, rd;
  logic [31:0] imm_ext, rs_val, rt_val, alu_b, alu_res, dmem_rd;
  logic [31:0] pc_plus4, br_target, jmp_target, pc_next;
  logic        dst_rd, use_imm, from_mem, wr_en, st_en, is_br, is_jmp;
  logic [1:0]  alu_mode;
  logic [2:0]  alu_fn;
  logic        fn_ok, zero;

  assign pc      = pc_q;
  assign instr   = imem[pc_q[IMEM_AW+1:2]];
  assign opcode  = instr[31:26];
  assign rs      = instr[25:21];
  assign rt      = instr[20:16];
  assign rd      = instr[15:11];
  assign funct   = instr[5:0];
  assign imm_ext = {{16{instr[15]}}, instr[15:0]};

  assign rs_val = (rs == 5'd0) ? 32'd0 : rf[rs];
  assign rt_val = (rt == 5'd0) ? 32'd0 : rf[rt];

  always_comb begin
    dst_rd = 1'b0; use_imm = 1'b0; from_mem = 1'b0; wr_en = 1'b0;
    st_en = 1'b0; is_br = 1'b0; is_jmp = 1'b0; alu_mode = 2'd0;
    case (opcode)
      OP_REG: begin dst_rd = 1'b1; wr_en = 1'b1; alu_mode = 2'd2; end
      OP_LD:  begin use_imm = 1'b1; from_mem = 1'b1; wr_en = 1'b1; end
      OP_ST:  begin use_imm = 1'b1; st_en = 1'b1; end
      OP_BR:  begin is_br = 1'b1; alu_mode = 2'd1; end
      OP_JMP: is_jmp = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    alu_fn = A_ADD;
    fn_ok  = 1'b1;
    case (alu_mode)
      2'd0: alu_fn = A_ADD;
      2'd1: alu_fn = A_SUB;
      default: begin
        case (funct)
          FN_ADD: alu_fn = A_ADD;
          FN_SUB: alu_fn = A_SUB;
          FN_AND: alu_fn = A_AND;
          FN_OR:  alu_fn = A_OR;
          FN_SLT: alu_fn = A_SLT;
          default: fn_ok = 1'b0;
        endcase
      end
    endcase
  end

  assign alu_b = use_imm ? imm_ext : rt_val;

  always_comb begin
    case (alu_fn)
      A_AND:   alu_res = rs_val & alu_b;
      A_OR:    alu_res = rs_val | alu_b;
      A_SUB:   alu_res = rs_val - alu_b;
      A_SLT:   alu_res = {31'd0, $signed(rs_val) < $signed(alu_b)};
      default: alu_res = rs_val + alu_b;
    endcase
  end

  assign zero    = (alu_res == 32'd0);
  assign dmem_rd = dmem[alu_res[DMEM_AW+1:2]];

  assign reg_waddr = dst_rd ? rd : rt;
  assign reg_wdata = from_mem ? dmem_rd : alu_res;
  assign reg_we    = wr_en & fn_ok & (reg_waddr != 5'd0);
  assign mem_we    = st_en;
  assign mem_addr  = alu_res;
  assign mem_wdata = rt_val;

  assign pc_plus4   = pc_q + 32'd4;
  assign br_target  = pc_plus4 + {imm_ext[29:0], 2'b00};
  assign jmp_target = {pc_plus4[31:28], instr[25:0], 2'b00};
  assign pc_next    = is_jmp ? jmp_target :
                      (is_br && zero) ? br_target : pc_plus4;

  always_ff @(posedge clk) begin
    if (rst) pc_q <= 32'd0;
    else     pc_q <= pc_next;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 32; i++) rf[i] <= 32'd0;
    end else if (reg_we) begin
      rf[reg_waddr] <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_imem_we) imem[ld_addr] <= ld_data;
  end

  always_ff @(posedge clk) begin
    if (ld_dmem_we)  dmem[ld_addr[DMEM_AW-1:0]] <= ld_data;
    else if (mem_we) dmem[alu_res[DMEM_AW+1:2]] <= rt_val;
  end
endmodule

module mini_cpu32_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] pc,
  input logic [31:0] instr,
  input logic        reg_we,
  input logic        mem_we,
  input logic [31:0] rs_val,
  input logic [31:0] rt_val
);
  logic [5:0]  op;
  logic [31:0] seq_pc, br_pc, jp_pc;
  assign op     = instr[31:26];
  assign seq_pc = pc + 32'd4;
  assign br_pc  = seq_pc + {{14{instr[15]}}, instr[15:0], 2'b00};
  assign jp_pc  = {seq_pc[31:28], instr[25:0], 2'b00};

  p_reset_pc_r1: assert property (@(posedge clk) rst |=> pc == 32'd0);

  p_seq_pc_r2: assert property (@(posedge clk) disable iff (rst)
    (op != 6'h04 && op != 6'h02) |=> pc == $past(seq_pc));

  p_pc_align_r2: assert property (@(posedge clk) disable iff (rst)
    pc[1:0] == 2'b00);

  p_store_only_r5: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (op == 6'h2B && !reg_we));

  p_br_taken_r6: assert property (@(posedge clk) disable iff (rst)
    (op == 6'h04 && rs_val == rt_val) |=> pc == $past(br_pc));

  p_br_fall_r6: assert property (@(posedge clk) disable iff (rst)
    (op == 6'h04 && rs_val != rt_val) |=> pc == $past(seq_pc));

  p_ctl_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (op == 6'h04 || op == 6'h02) |-> (!reg_we && !mem_we));

  p_jump_pc_r7: assert property (@(posedge clk) disable iff (rst)
    (op == 6'h02) |=> pc == $past(jp_pc));
endmodule

bind mini_cpu32 mini_cpu32_chk u_chk (
  .clk(clk), .rst(rst), .pc(pc), .instr(instr), .reg_we(reg_we),
  .mem_we(mem_we), .rs_val(rs_val), .rt_val(rt_val)
);

// File: tb/sim_mini_cpu32.sv
module sim_mini_cpu32;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_imem_we = 1'b0, ld_dmem_we = 1'b0;
  logic [7:0]  ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic [31:0] pc, instr, reg_wdata, mem_addr, mem_wdata;
  logic        reg_we, mem_we;
  logic [4:0]  reg_waddr;

  always #5 clk = ~clk;

  mini_cpu32 #(.IMEM_AW(8), .DMEM_AW(6)) u0 (
    .clk(clk), .rst(rst), .ld_imem_we(ld_imem_we), .ld_dmem_we(ld_dmem_we),
    .ld_addr(ld_addr), .ld_data(ld_data), .pc(pc), .instr(instr),
    .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  int vectors = 0;
  int fails   = 0;
  int n       = 0;
  logic [31:0] prog [256];
  logic [31:0] dm   [64];
  logic [31:0] regs [32];
  logic [31:0] mpc;

  function automatic logic [31:0] enc_r(int s, int t, int d, logic [5:0] f);
    return {6'h00, 5'(s), 5'(t), 5'(d), 5'd0, f};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int s, int t, int imm);
    logic [31:0] v = imm;
    return {op, 5'(s), 5'(t), v[15:0]};
  endfunction
  function automatic logic [31:0] enc_j(int word);
    logic [31:0] v = word;
    return {6'h02, v[25:0]};
  endfunction

  task automatic emit(input logic [31:0] w);
    prog[n] = w;
    n++;
  endtask

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 32; i++) regs[i] = 32'd0;
    mpc = 32'd0;
  endtask

  task automatic step();
    logic [31:0] w, a, b, sx, res, addr, npc;
    logic [5:0]  op, fn;
    int          s, t, d;
    logic        e_we, e_mwe;
    logic [4:0]  e_wa;
    logic [31:0] e_wd;
    string       tag, ptag;
    w  = prog[mpc[9:2]];
    op = w[31:26]; fn = w[5:0];
    s = int'(w[25:21]); t = int'(w[20:16]); d = int'(w[15:11]);
    a = regs[s]; b = regs[t];
    sx = {{16{w[15]}}, w[15:0]};
    npc = mpc + 32'd4;
    e_we = 1'b0; e_mwe = 1'b0; e_wa = 5'd0; e_wd = 32'd0;
    res = 32'd0; addr = 32'd0;
    tag = "R3";
    case (op)
      6'h00: begin
        case (fn)
          6'h20: res = a + b;
          6'h22: res = a - b;
          6'h24: res = a & b;
          6'h25: res = a | b;
          default: res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
        endcase
        e_we = (d != 0); e_wa = 5'(d); e_wd = res;
        if (d == 0 || s == 0 || t == 0) tag = "R8";
      end
      6'h23: begin
        addr = a + sx;
        e_we = (t != 0); e_wa = 5'(t); e_wd = dm[addr[7:2]];
        tag = "R4";
      end
      6'h2B: begin
        addr = a + sx; e_mwe = 1'b1; tag = "R5";
      end
      6'h04: begin
        if (a == b) npc = mpc + 32'd4 + {sx[29:0], 2'b00};
        tag = "R6";
      end
      default: begin
        npc = {npc[31:28], w[25:0], 2'b00};
        tag = "R7";
      end
    endcase
    if (mpc == 32'd0) tag = "R1";
    ptag = (op == 6'h04 || op == 6'h02) ? tag : "R2";
    check(ptag, "pc", pc, mpc);
    check("R9", "instr", instr, w);
    check(tag, "reg_we", {31'd0, reg_we}, {31'd0, e_we});
    if (e_we) begin
      check(tag, "reg_waddr", {27'd0, reg_waddr}, {27'd0, e_wa});
      check(tag, "reg_wdata", reg_wdata, e_wd);
    end
    check(tag, "mem_we", {31'd0, mem_we}, {31'd0, e_mwe});
    if (e_mwe) begin
      check("R5", "mem_addr", mem_addr, addr);
      check("R5", "mem_wdata", mem_wdata, b);
    end
    if (e_we) regs[e_wa] = e_wd;
    if (e_mwe) dm[addr[7:2]] = b;
    mpc = npc;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int k;
    logic [5:0] fns [5];
    fns[0] = 6'h20; fns[1] = 6'h22; fns[2] = 6'h24; fns[3] = 6'h25; fns[4] = 6'h2A;
    for (int i = 0; i < 256; i++) prog[i] = 32'd0;
    for (int i = 0; i < 64; i++) dm[i] = 32'h1000 + i;
    dm[0] = 32'd1;          dm[1] = 32'd3;          dm[2] = 32'hFFFF_FFFF;
    dm[3] = 32'h7FFF_FFFF;  dm[4] = 32'h8000_0000;  dm[5] = 32'd5;
    dm[6] = 32'hFFFF_FFF9;  dm[7] = 32'hA5A5_0F0F;  dm[8] = 32'h0000_0080;

    emit(enc_r(5, 6, 9, 6'h20));
    for (int i = 1; i <= 8; i++) emit(enc_i(6'h23, 0, i, (i - 1) * 4));
    emit(enc_i(6'h23, 0, 31, 32));
    k = 0;
    for (int ra = 1; ra <= 5; ra++)
      for (int rb = 1; rb <= 5; rb++)
        for (int f = 0; f < 5; f++) begin
          emit(enc_r(ra, rb, 9 + (k % 20), fns[f]));
          k++;
        end
    emit(enc_r(1, 2, 0, 6'h20));
    emit(enc_r(0, 3, 29, 6'h20));
    emit(enc_r(0, 0, 28, 6'h25));
    emit(enc_i(6'h2B, 31, 3, -4));
    emit(enc_i(6'h23, 31, 29, -4));
    emit(enc_i(6'h2B, 31, 7, 8));
    emit(enc_i(6'h23, 31, 30, 8));
    emit(enc_i(6'h2B, 0, 8, 0));
    emit(enc_i(6'h23, 0, 28, 0));
    emit(enc_i(6'h04, 1, 1, 1));
    emit(enc_r(1, 1, 9, 6'h20));
    emit(enc_i(6'h04, 1, 2, 1));
    emit(enc_r(2, 2, 9, 6'h20));
    emit(enc_r(0, 0, 10, 6'h20));
    emit(enc_r(10, 1, 10, 6'h20));
    emit(enc_i(6'h04, 10, 2, 1));
    emit(enc_i(6'h04, 0, 0, -3));
    emit(enc_j(n + 2));
    emit(enc_r(1, 1, 11, 6'h20));
    emit(enc_j(n));

    // R9: fill both memories through the load port while reset is held
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      ld_imem_we = 1'b1; ld_dmem_we = 1'b0; ld_addr = 8'(i); ld_data = prog[i];
    end
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      ld_imem_we = 1'b0; ld_dmem_we = 1'b1; ld_addr = 8'(i); ld_data = dm[i];
    end
    @(negedge clk);
    ld_imem_we = 1'b0; ld_dmem_we = 1'b0;
    @(negedge clk);
    check("R1", "pc in reset", pc, 32'd0);
    model_reset();
    rst = 1'b0;

    for (int c = 0; c < 30; c++) begin
      #1 step();
      @(negedge clk);
    end
    // R1: reset again from a running state with live registers
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1", "pc after mid-run reset", pc, 32'd0);
    rst = 1'b0;
    model_reset();
    for (int c = 0; c < 200; c++) begin
      #1 step();
      @(negedge clk);
    end
    finish_run();
  end
endmodule